// File: doc/BRIEF.md
# Timestamped Event-Condition-Action Scheduler

This block turns incoming timing events into actions that happen at a fixed clock edge. Each event arrives with an identifier and an absolute due time, counted in ticks of a local 64-bit time counter. A host first fills a condition table. Each entry holds a reference identifier, a compare mask, an action kind, a slave index and a 32-bit parameter. When an event arrives, the lowest-numbered enabled entry whose masked identifier bits match supplies the action. Events that match no entry are discarded.

Matched actions whose due time is still ahead go into a pending store of eight slots. The earliest due action is released on the first cycle in which local time has reached its due time. There are three kinds of action:

- an interrupt line that stays set until the host clears it;
- a pulse on a discrete output whose length comes from the parameter;
- a one-cycle command strobe on a parallel slave bus, which carries the slave index and the parameter.

An event whose due time has already arrived is executed at once, and a sticky late flag records it. A matched event that finds the store full is lost, and a sticky overflow flag records it. A scheduled action cannot be withdrawn.

The local counter advances by one every clock and can be loaded from an external synchronisation source.

Top module: `eca_scheduler`

## Requirements
- R1: After reset, time_now is 0 and irq, pulse_out, bus_valid, late_flag and ovf_flag are all 0.
- R2: time_now increases by exactly 1 per clock. When time_load is high at an edge, time_now takes time_load_val at that edge.
- R3: Entry kind encoding is 0 = disabled, 1 = interrupt, 2 = pulse, 3 = bus command. An entry hits when its kind is not 0 and ev_id equals the entry identifier on every bit where the mask is 1. An event with no hit produces no action and sets no flag.
- R4: When several entries hit, the lowest-indexed entry alone supplies the action.
- R5: A queued action's outputs appear in the cycle right after the first cycle in which time_now >= its due time, and never earlier.
- R6: Pending actions are released earliest due time first, one per cycle.
- R7: When a matched event arrives with due time <= time_now, its action appears in the next cycle and late_flag is set. late_flag stays 1 until flag_clr.
- R8: When all 8 pending slots are full, a matched future event is dropped and never executed, and ovf_flag is set. ovf_flag stays 1 until flag_clr.
- R9: An interrupt action sets irq, which holds until irq_clr. If a new interrupt action and irq_clr fall in the same cycle, irq stays 1.
- R10: A pulse action drives pulse_out high for param[15:0] consecutive cycles. A length of 0 is treated as 1.
- R11: A bus action raises bus_valid for exactly one cycle, with bus_slave set to the slave index and bus_data set to the parameter. A slave index of 12 or more produces no strobe.
- R12: Rewriting a condition entry after an action has been scheduled does not change the pending action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| time_load | input | 1 | Load local time from time_load_val |
| time_load_val | input | 64 | Synchronised time value |
| time_now | output | 64 | Local time counter |
| ev_valid | input | 1 | Event present this cycle |
| ev_id | input | 64 | Event identifier |
| ev_due | input | 64 | Absolute due time of the event |
| cfg_we | input | 1 | Write condition entry |
| cfg_idx | input | 4 | Entry index |
| cfg_id | input | 64 | Reference identifier |
| cfg_mask | input | 64 | Compare mask, 1 = bit compared |
| cfg_kind | input | 2 | Action kind (see R3) |
| cfg_slave | input | 4 | Slave index for bus actions |
| cfg_param | input | 32 | Pulse length or bus data |
| irq_clr | input | 1 | Clear the interrupt line |
| flag_clr | input | 1 | Clear late and overflow flags |
| irq | output | 1 | Interrupt request |
| pulse_out | output | 1 | Discrete pulse output |
| bus_valid | output | 1 | Slave bus command strobe |
| bus_slave | output | 4 | Addressed slave |
| bus_data | output | 32 | Command data |
| late_flag | output | 1 | Sticky late-event flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong earliest-slot choice in the pending store appears at bus_data as a reordered strobe sequence, on the very first release after two actions are pending. A slot that is not freed, or is freed twice, shows up as a lost or repeated strobe, or as an overflow flag raised one event too soon. A faulty compare or priority chain shows at the next cycle's output on a late event, so the random stream of late events exposes it within one cycle of the first ambiguous identifier.

// File: rtl/eca_pkg.sv
package eca_pkg;
    localparam int TIME_W  = 64;
    localparam int ID_W    = 64;
    localparam int PARAM_W = 32;
    localparam int SLV_W   = 4;

    typedef enum logic [1:0] {
        ACT_OFF   = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_PULSE = 2'd2,
        ACT_BUS   = 2'd3
    } act_kind_e;

    typedef struct packed {
        act_kind_e          kind;
        logic [SLV_W-1:0]   slave;
        logic [PARAM_W-1:0] param;
    } action_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic [ID_W-1:0] mask;
        action_t         act;
    } cond_t;

    typedef struct packed {
        logic              valid;
        logic [TIME_W-1:0] due;
        action_t           act;
    } slot_t;

    function automatic logic id_hit(input logic [ID_W-1:0] ev,
                                    input logic [ID_W-1:0] ref_id,
                                    input logic [ID_W-1:0] mask);
        return ((ev ^ ref_id) & mask) == '0;
    endfunction

    function automatic logic is_due(input logic [TIME_W-1:0] due,
                                    input logic [TIME_W-1:0] now);
        return due <= now;
    endfunction
endpackage

// File: rtl/eca_cond_table.sv
module eca_cond_table
    import eca_pkg::*;
#(
    parameter int N_COND = 16,
    localparam int IDX_W = (N_COND > 1) ? $clog2(N_COND) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cond_t           wr_cond,
    input  logic [ID_W-1:0] ev_id,
    output logic            hit,
    output action_t         hit_act
);
    cond_t             tbl [N_COND];
    logic [N_COND-1:0] hit_vec;
    logic [IDX_W-1:0]  hit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_COND; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_cond;
        end
    end

    for (genvar g = 0; g < N_COND; g++) begin : g_cmp
        assign hit_vec[g] = (tbl[g].act.kind != ACT_OFF) &&
                            id_hit(ev_id, tbl[g].id, tbl[g].mask);
    end

    // lowest index wins (R4)
    always_comb begin
        hit_idx = '0;
        for (int i = N_COND - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit     = |hit_vec;
    assign hit_act = tbl[hit_idx].act;

    a_r3_hit_enabled: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_act.kind != ACT_OFF));
endmodule

// File: rtl/eca_action_queue.sv
module eca_action_queue
    import eca_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now,
    input  logic              ins_en,
    input  logic [TIME_W-1:0] ins_due,
    input  action_t           ins_act,
    output logic              full,
    output logic              rel_avail,
    output action_t           rel_act,
    input  logic              rel_take
);
    slot_t             slots [DEPTH];
    logic [DEPTH-1:0]  vld;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  best_idx;
    logic              best_ok;
    logic [TIME_W-1:0] best_due;
    logic [CNT_W-1:0]  cnt;
    slot_t             ins_slot;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) vld[i] = slots[i].valid;
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && !found) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    // earliest due slot; strict compare keeps the lower slot on ties
    always_comb begin
        best_idx = '0;
        best_ok  = 1'b0;
        best_due = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (!best_ok || slots[i].due < best_due)) begin
                best_idx = IDX_W'(i);
                best_ok  = 1'b1;
                best_due = slots[i].due;
            end
        end
    end

    always_comb begin
        ins_slot.valid = 1'b1;
        ins_slot.due   = ins_due;
        ins_slot.act   = ins_act;
    end

    assign full      = &vld;
    assign rel_avail = best_ok && is_due(best_due, now);
    assign rel_act   = slots[best_idx].act;
    assign cnt       = CNT_W'($countones(vld));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (rel_take) slots[best_idx].valid <= 1'b0;
            if (ins_en)   slots[free_idx]       <= ins_slot;
        end
    end

    a_r8_no_insert_full: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !full);
    a_r8_count_grows: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !rel_take) |=> (cnt == $past(cnt) + 1'b1));
    a_r6_take_only_avail: assert property (@(posedge clk) disable iff (rst)
        rel_take |-> rel_avail);
endmodule

// File: rtl/eca_action_out.sv
module eca_action_out
    import eca_pkg::*;
#(
    parameter int N_SLAVE = 12,
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  action_t            fire_act,
    input  logic               irq_clr,
    output logic               irq,
    output logic               pulse_out,
    output logic               bus_valid,
    output logic [SLV_W-1:0]   bus_slave,
    output logic [PARAM_W-1:0] bus_data
);
    localparam logic [SLV_W:0] SLV_LIM = (SLV_W + 1)'(N_SLAVE);

    logic [PULSE_W-1:0] pulse_cnt;
    logic [PULSE_W-1:0] pulse_len;
    logic               do_irq, do_pulse, do_bus;

    assign do_irq    = fire && (fire_act.kind == ACT_IRQ);
    assign do_pulse  = fire && (fire_act.kind == ACT_PULSE);
    assign do_bus    = fire && (fire_act.kind == ACT_BUS) &&
                       ({1'b0, fire_act.slave} < SLV_LIM);
    assign pulse_len = (fire_act.param[PULSE_W-1:0] == '0) ?
                       PULSE_W'(1) : fire_act.param[PULSE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            pulse_cnt <= '0;
            bus_valid <= 1'b0;
            bus_slave <= '0;
            bus_data  <= '0;
        end else begin
            irq       <= do_irq || (irq && !irq_clr);
            bus_valid <= do_bus;
            if (do_bus) begin
                bus_slave <= fire_act.slave;
                bus_data  <= fire_act.param;
            end
            if (do_pulse)             pulse_cnt <= pulse_len;
            else if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign pulse_out = (pulse_cnt != '0);

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);
    a_r10_pulse_start: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_act.kind == ACT_PULSE) |=> pulse_out);
    a_r11_slave_range: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> ({1'b0, bus_slave} < SLV_LIM));
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !(fire && fire_act.kind == ACT_BUS)) |=> !bus_valid);
endmodule

// File: rtl/eca_scheduler.sv
module eca_scheduler
    import eca_pkg::*;
#(
    parameter int N_COND  = 16,
    parameter int Q_DEPTH = 8,
    parameter int N_SLAVE = 12,
    parameter int PULSE_W = 16,
    localparam int IDX_W  = (N_COND > 1) ? $clog2(N_COND) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               time_load,
    input  logic [63:0]        time_load_val,
    output logic [63:0]        time_now,
    input  logic               ev_valid,
    input  logic [63:0]        ev_id,
    input  logic [63:0]        ev_due,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [63:0]        cfg_id,
    input  logic [63:0]        cfg_mask,
    input  logic [1:0]         cfg_kind,
    input  logic [SLV_W-1:0]   cfg_slave,
    input  logic [PARAM_W-1:0] cfg_param,
    input  logic               irq_clr,
    input  logic               flag_clr,
    output logic               irq,
    output logic               pulse_out,
    output logic               bus_valid,
    output logic [SLV_W-1:0]   bus_slave,
    output logic [PARAM_W-1:0] bus_data,
    output logic               late_flag,
    output logic               ovf_flag
);
    cond_t   wr_c;
    logic    hit;
    action_t hit_act;
    logic    is_late;
    logic    late_fire, q_ins, q_drop;
    logic    q_full, q_avail, q_take;
    action_t q_act;
    logic    fire;
    action_t fire_act;

    always_comb begin
        wr_c.id         = cfg_id;
        wr_c.mask       = cfg_mask;
        wr_c.act.kind   = act_kind_e'(cfg_kind);
        wr_c.act.slave  = cfg_slave;
        wr_c.act.param  = cfg_param;
    end

    always_ff @(posedge clk) begin
        if (rst)            time_now <= '0;
        else if (time_load) time_now <= time_load_val;
        else                time_now <= time_now + 64'd1;
    end

    eca_cond_table #(.N_COND(N_COND)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_cond (wr_c),
        .ev_id   (ev_id),
        .hit     (hit),
        .hit_act (hit_act)
    );

    assign is_late   = is_due(ev_due, time_now);
    assign late_fire = ev_valid && hit && is_late;
    assign q_ins     = ev_valid && hit && !is_late && !q_full;
    assign q_drop    = ev_valid && hit && !is_late && q_full;

    eca_action_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .now       (time_now),
        .ins_en    (q_ins),
        .ins_due   (ev_due),
        .ins_act   (hit_act),
        .full      (q_full),
        .rel_avail (q_avail),
        .rel_act   (q_act),
        .rel_take  (q_take)
    );

    // a late event takes the output stage; a due queue entry waits one cycle
    assign q_take   = q_avail && !late_fire;
    assign fire     = late_fire || q_avail;
    assign fire_act = late_fire ? hit_act : q_act;

    eca_action_out #(.N_SLAVE(N_SLAVE), .PULSE_W(PULSE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_act  (fire_act),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .pulse_out (pulse_out),
        .bus_valid (bus_valid),
        .bus_slave (bus_slave),
        .bus_data  (bus_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            late_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            late_flag <= late_fire || (late_flag && !flag_clr);
            ovf_flag  <= q_drop    || (ovf_flag  && !flag_clr);
        end
    end

    a_r2_time_step: assert property (@(posedge clk) disable iff (rst)
        !time_load |=> (time_now == $past(time_now) + 64'd1));
    a_r7_late_flag: assert property (@(posedge clk) disable iff (rst)
        late_fire |=> late_flag);
    a_r8_ovf_flag: assert property (@(posedge clk) disable iff (rst)
        q_drop |=> ovf_flag);
    a_r7_late_bus_now: assert property (@(posedge clk) disable iff (rst)
        (late_fire && hit_act.kind == ACT_BUS && hit_act.slave < SLV_W'(N_SLAVE))
        |=> (bus_valid && bus_data == $past(hit_act.param)));
endmodule

// File: tb/test_eca_scheduler.sv
module test_eca_scheduler;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        time_load = 1'b0;
    logic [63:0] time_load_val = '0;
    logic [63:0] time_now;
    logic        ev_valid = 1'b0;
    logic [63:0] ev_id = '0;
    logic [63:0] ev_due = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [63:0] cfg_id = '0;
    logic [63:0] cfg_mask = '0;
    logic [1:0]  cfg_kind = '0;
    logic [3:0]  cfg_slave = '0;
    logic [31:0] cfg_param = '0;
    logic        irq_clr = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq, pulse_out, bus_valid, late_flag, ovf_flag;
    logic [3:0]  bus_slave;
    logic [31:0] bus_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_id   [16];
    logic [63:0] m_mask [16];
    logic [1:0]  m_kind [16];
    logic [3:0]  m_slv  [16];
    logic [31:0] m_par  [16];

    always #10 clk = ~clk;

    eca_scheduler i_eca_scheduler (
        .clk(clk), .rst(rst), .time_load(time_load), .time_load_val(time_load_val),
        .time_now(time_now), .ev_valid(ev_valid), .ev_id(ev_id), .ev_due(ev_due),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_mask(cfg_mask),
        .cfg_kind(cfg_kind), .cfg_slave(cfg_slave), .cfg_param(cfg_param),
        .irq_clr(irq_clr), .flag_clr(flag_clr), .irq(irq), .pulse_out(pulse_out),
        .bus_valid(bus_valid), .bus_slave(bus_slave), .bus_data(bus_data),
        .late_flag(late_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [63:0] id, input logic [63:0] mask,
                      input logic [1:0] kind, input logic [3:0] slv, input logic [31:0] par);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_id = id; cfg_mask = mask;
        cfg_kind = kind; cfg_slave = slv; cfg_param = par;
        m_id[idx] = id; m_mask[idx] = mask; m_kind[idx] = kind;
        m_slv[idx] = slv; m_par[idx] = par;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [63:0] id, input logic [63:0] due);
        ev_valid = 1'b1; ev_id = id; ev_due = due;
        tick();
        ev_valid = 1'b0;
    endtask

    task automatic pulse_clr_flags();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    function automatic int exp_match(input logic [63:0] id);
        for (int i = 0; i < 16; i++) begin
            if (m_kind[i] != 2'd0 && ((id ^ m_id[i]) & m_mask[i]) == 64'd0) return i;
        end
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam logic [63:0] ONES = '1;

    initial begin
        logic [63:0] base;
        logic [63:0] t0;
        int          hi;
        int          seen;
        bit          early;
        logic [31:0] got_d [3];
        logic [63:0] got_t [3];
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin
            m_id[i] = '0; m_mask[i] = '0; m_kind[i] = '0; m_slv[i] = '0; m_par[i] = '0;
        end

        // R1 reset state
        tick(); tick();
        chk(time_now == 64'd0, "R1 time_now in reset", time_now, 0);
        chk({irq, pulse_out, bus_valid, late_flag, ovf_flag} == 5'b0,
            "R1 outputs in reset", {irq, pulse_out, bus_valid, late_flag, ovf_flag}, 0);
        rst = 1'b0;
        tick();
        // R2 counting and loading
        t0 = time_now;
        tick();
        chk(time_now == t0 + 1, "R2 time increment", time_now, t0 + 1);
        time_load = 1'b1; time_load_val = 64'd1000;
        tick();
        time_load = 1'b0;
        chk(time_now == 64'd1000, "R2 time load", time_now, 1000);

        // R5 scheduled release edge
        wr(0, 64'h100, ONES, 2'd3, 4'd2, 32'hB0);
        base = time_now;
        send(64'h100, base + 10);
        early = 1'b0;
        while (time_now != base + 11) begin
            if (bus_valid) early = 1'b1;
            tick();
        end
        chk(!early, "R5 no strobe before due", early, 0);
        chk(bus_valid && bus_data == 32'hB0 && bus_slave == 4'd2,
            "R5 strobe after due", {bus_valid, bus_slave, bus_data}, {1'b1, 4'd2, 32'hB0});
        tick();
        chk(!bus_valid, "R11 strobe one cycle", bus_valid, 0);

        // R3 unmatched, masked and disabled entries
        send(64'h101, 64'd0);
        chk(!bus_valid && !late_flag, "R3 unmatched dropped", {bus_valid, late_flag}, 0);
        wr(1, 64'hAB00, 64'hFF00, 2'd3, 4'd3, 32'hB1);
        send(64'hAB7F, 64'd0);
        chk(bus_valid && bus_data == 32'hB1, "R3 masked hit", bus_data, 32'hB1);
        chk(late_flag, "R7 late flag set", late_flag, 1);
        tick(); tick();
        chk(late_flag, "R7 late flag sticky", late_flag, 1);
        pulse_clr_flags();
        chk(!late_flag, "R7 late flag cleared", late_flag, 0);
        wr(2, 64'h200, ONES, 2'd0, 4'd0, 32'hB2);
        send(64'h200, 64'd0);
        chk(!bus_valid && !late_flag, "R3 disabled entry", {bus_valid, late_flag}, 0);

        // R4 priority
        wr(4, 64'h3000, 64'hF000, 2'd3, 4'd1, 32'hC4);
        wr(5, 64'h3456, ONES, 2'd3, 4'd1, 32'hC5);
        send(64'h3456, 64'd0);
        chk(bus_data == 32'hC4 && bus_valid, "R4 lowest index wins", bus_data, 32'hC4);
        wr(4, 64'h3000, 64'hF000, 2'd0, 4'd1, 32'hC4);
        send(64'h3456, 64'd0);
        chk(bus_data == 32'hC5 && bus_valid, "R4 next entry after disable", bus_data, 32'hC5);

        // R9 interrupt
        wr(6, 64'h600, ONES, 2'd1, 4'd0, 32'd0);
        send(64'h600, 64'd0);
        chk(irq, "R9 irq set", irq, 1);
        tick(); tick(); tick();
        chk(irq, "R9 irq holds", irq, 1);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk(!irq, "R9 irq cleared", irq, 0);
        irq_clr = 1'b1; send(64'h600, 64'd0); irq_clr = 1'b0;
        chk(irq, "R9 set beats clear", irq, 1);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;

        // R10 pulse length
        wr(7, 64'h700, ONES, 2'd2, 4'd0, 32'd3);
        send(64'h700, 64'd0);
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            if (pulse_out) hi++;
            tick();
        end
        chk(hi == 3, "R10 pulse length 3", hi, 3);
        wr(7, 64'h700, ONES, 2'd2, 4'd0, 32'd0);
        send(64'h700, 64'd0);
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            if (pulse_out) hi++;
            tick();
        end
        chk(hi == 1, "R10 zero length as one", hi, 1);

        // R11 slave range
        wr(8, 64'h800, ONES, 2'd3, 4'd12, 32'hD8);
        send(64'h800, 64'd0);
        chk(!bus_valid, "R11 slave 12 suppressed", bus_valid, 0);
        wr(8, 64'h800, ONES, 2'd3, 4'd11, 32'hD9);
        send(64'h800, 64'd0);
        chk(bus_valid && bus_slave == 4'd11, "R11 slave 11 strobe", bus_slave, 11);

        // R6 earliest first
        wr(9,  64'h900, ONES, 2'd3, 4'd1, 32'hE1);
        wr(10, 64'hA00, ONES, 2'd3, 4'd1, 32'hE2);
        wr(11, 64'hB00, ONES, 2'd3, 4'd1, 32'hE3);
        base = time_now;
        send(64'h900, base + 60);
        send(64'hA00, base + 40);
        send(64'hB00, base + 50);
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            if (bus_valid) begin
                if (seen < 3) begin got_d[seen] = bus_data; got_t[seen] = time_now; end
                seen++;
            end
            tick();
        end
        chk(seen == 3, "R6 three releases", seen, 3);
        chk(got_d[0] == 32'hE2 && got_t[0] == base + 41, "R6 first release", got_d[0], 32'hE2);
        chk(got_d[1] == 32'hE3 && got_t[1] == base + 51, "R6 second release", got_d[1], 32'hE3);
        chk(got_d[2] == 32'hE1 && got_t[2] == base + 61, "R6 third release", got_d[2], 32'hE1);

        // R12 no cancel after rewrite
        wr(12, 64'hC00, ONES, 2'd3, 4'd5, 32'h55);
        base = time_now;
        send(64'hC00, base + 20);
        wr(12, 64'hC00, ONES, 2'd0, 4'd5, 32'h99);
        while (!bus_valid && time_now < base + 40) tick();
        chk(bus_valid && bus_data == 32'h55, "R12 pending action kept", bus_data, 32'h55);
        tick();

        // R8 overflow
        pulse_clr_flags();
        wr(13, 64'hD00, ONES, 2'd3, 4'd6, 32'h0D);
        base = time_now;
        for (int i = 0; i < 8; i++) send(64'hD00, base + 100 + 64'(i) * 3);
        chk(!ovf_flag, "R8 no overflow at 8", ovf_flag, 0);
        send(64'hD00, base + 200);
        chk(ovf_flag, "R8 overflow flag", ovf_flag, 1);
        seen = 0;
        for (int i = 0; i < 250; i++) begin
            if (bus_valid) seen++;
            tick();
        end
        chk(seen == 8, "R8 dropped event not run", seen, 8);
        chk(ovf_flag, "R8 overflow sticky", ovf_flag, 1);
        pulse_clr_flags();
        chk(!ovf_flag, "R8 overflow cleared", ovf_flag, 0);

        // R3 R4 R11 random table and late events
        for (int k = 0; k < 16; k++) begin
            logic [63:0] rid, rmask;
            logic [1:0]  rk;
            rid   = {48'd0, 16'($urandom)};
            rmask = {48'hFFFF_FFFF_FFFF, 16'($urandom & $urandom)};
            rk    = ($urandom % 4 == 0) ? 2'd0 : 2'd3;
            wr(k, rid, rmask, rk, 4'($urandom % 16), 32'hF000 + 32'(k));
        end
        for (int n = 0; n < 60; n++) begin
            logic [63:0] eid;
            int          e;
            if ($urandom % 2 == 0) begin
                int j;
                j   = $urandom % 16;
                eid = m_id[j] ^ ({48'd0, 16'($urandom)} & ~m_mask[j]);
            end else begin
                eid = {48'd0, 16'($urandom)};
                if ($urandom % 8 == 0) eid[40] = 1'b1;
            end
            e = exp_match(eid);
            send(eid, 64'd0);
            if (e < 0 || m_slv[e] >= 4'd12) begin
                chk(!bus_valid, "R3 random no strobe", bus_valid, 0);
            end else begin
                chk(bus_valid && bus_data == m_par[e] && bus_slave == m_slv[e],
                    "R4 random match", {bus_valid, bus_slave, bus_data},
                    {1'b1, m_slv[e], m_par[e]});
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule